// File: doc/BRIEF.md
# Configurable SPI Master Shifter

This block is a serial peripheral master that runs entirely from the system clock. Writing a word starts a transfer. The block then drives the serial clock and the outgoing data line, and it captures the incoming data line on the opposite clock edge. It supports all four clock polarity and phase combinations, a word length of 2 to 16 bits, and either bit order. The half period of the serial clock is set in system-clock cycles, so every timing relation below is an exact count of those cycles.

The block latches the configuration inputs in the cycle a write is accepted, so a host may change them freely while a word is in flight. Data moves as plain strobes. A write is taken only while the block is idle, and there is no back-pressure: a write that arrives while busy is dropped and recorded in a sticky flag. The received word is presented together with a one-cycle done pulse and keeps its value until the next transfer ends. There is no ready on the receive side, so the host must take the word when done rises or read it later from the held output.

Below, the "accept edge" is the clock edge at which a write is taken, H is the clamped half period and N is the clamped word length.

Top module: `spi_xfer_master`

## Requirements
- R1: H is `cfg_half` limited to the range 4 to 128. The serial clock therefore toggles every H system cycles, for a period of 8 to 256 cycles.
- R2: While no word is in flight, `sclk` follows `cfg_cpol` with one cycle of delay. After reset it starts at 0.
- R3: With phase 0, the first data bit appears on `mosi` at the accept edge, and the first `sclk` edge comes 4 cycles later.
- R4: With phase 1, the first data bit appears on `mosi` at the accept edge, and the first `sclk` edge comes H+4 cycles later.
- R5: With phase 0, `miso` is sampled on the leading edges and `mosi` changes on the trailing edges. With phase 1 the two roles are swapped. The leading edge is rising for polarity 0 and falling for polarity 1.
- R6: When `cfg_lsb_first`=0, bit N-1 is sent first. When it is 1, bit 0 is sent first. Received bits are stored right-aligned in the same order: the first bit received goes to bit N-1 (MSB first) or to bit 0 (LSB first), and bits N and above read 0.
- R7: N is `cfg_len` limited to the range 2 to 16. Exactly N clock pulses (2N edges) are produced per word.
- R8: After the last bit, `mosi` holds its value until the next accepted write.
- R9: `busy` rises at the accept edge and falls one cycle after the final `sclk` edge. At that same point `done` pulses for one cycle and `rx_data` takes the new word. After reset, all outputs are 0.
- R10: A write while `busy` is ignored and has no effect on the word in flight. It sets `overrun`, which stays set until reset.
- R11: The configuration inputs are captured at the accept edge. Changing them during a word does not alter that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Phase select: 0 samples on the leading edge |
| cfg_lsb_first | input | 1 | Bit order: 1 sends bit 0 first |
| cfg_len | input | 5 | Word length in bits, limited to 2..16 |
| cfg_half | input | 8 | Half period in system cycles, limited to 4..128 |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 16 | Transmit word, right-aligned |
| busy | output | 1 | A word is in flight |
| done | output | 1 | One-cycle end-of-word pulse |
| rx_data | output | 16 | Last received word, right-aligned |
| overrun | output | 1 | Sticky flag: a write arrived while busy |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is a write that lands in the middle of a word while the configuration inputs change at the same moment. The block must keep shifting the original word with its latched settings, and it must also set the sticky flag. The bench reaches this by starting a word, waiting part way into it, and then pulsing the write strobe with a different word while toggling bit order, polarity, length and half period together. The clamp limits (half period 2 and 200, length 1 and 31) are run through complete words. A loopback from `mosi` to `miso` makes the received word equal the sent one in every mode, and a random `miso` stream checks the receive ordering on its own.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_RUN  = 2'd1,
    XS_FIN  = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/spi_xfer_clamp.sv
module spi_xfer_clamp #(
  parameter int W  = 8,
  parameter int LO = 0,
  parameter int HI = 255
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] lim
);
  always_comb begin
    if (raw < W'(LO))      lim = W'(LO);
    else if (raw > W'(HI)) lim = W'(HI);
    else                   lim = raw;
  end
endmodule

// File: rtl/spi_xfer_bitsel.sv
// Maps the ordinal of a bit on the wire to its position in the word.
module spi_xfer_bitsel #(
  parameter int LEN_W = 5,
  parameter int BIT_W = 4
) (
  input  logic             lsb_first,
  input  logic [LEN_W-1:0] len,
  input  logic [BIT_W-1:0] ord,
  output logic [BIT_W-1:0] pos
);
  logic [LEN_W-1:0] rev;
  assign rev = len - LEN_W'(1) - LEN_W'(ord);
  assign pos = lsb_first ? ord : BIT_W'(rev);
endmodule

// File: rtl/spi_xfer_timer.sv
// Counts system cycles to each serial clock edge and numbers the edges.
module spi_xfer_timer #(
  parameter int HALF_W = 8,
  parameter int CNT_W  = 8,
  parameter int IDX_W  = 5,
  parameter int LEAD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cpha,
  input  logic [HALF_W-1:0] half,
  input  logic [IDX_W-1:0]  last_idx,
  output logic              fire,
  output logic              final_edge,
  output logic [IDX_W-1:0]  edge_idx
);
  localparam logic [CNT_W-1:0] LEAD_M1 = CNT_W'(LEAD - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  assign fire       = run_q && (cnt_q == '0);
  assign final_edge = fire && (idx_q == last_idx);
  assign edge_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      idx_q <= '0;
      cnt_q <= cpha ? (CNT_W'(half) + LEAD_M1) : LEAD_M1;
    end else if (fire) begin
      cnt_q <= CNT_W'(half) - CNT_W'(1);
      idx_q <= idx_q + IDX_W'(1);
      if (final_edge) run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_xfer_rxasm.sv
// Collects received bits at computed positions into a right-aligned word.
module spi_xfer_rxasm #(
  parameter int W     = 16,
  parameter int BIT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             cap,
  input  logic [BIT_W-1:0] pos,
  input  logic             din,
  output logic [W-1:0]     word
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            word[i] <= 1'b0;
      else if (clear)                        word[i] <= 1'b0;
      else if (cap && (pos == BIT_W'(i)))    word[i] <= din;
    end
  end
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
  parameter int MAX_LEN  = 16,
  parameter int MIN_LEN  = 2,
  parameter int MIN_HALF = 4,
  parameter int MAX_HALF = 128,
  parameter int LEAD     = 4,
  localparam int LEN_W   = $clog2(MAX_LEN + 1),
  localparam int HALF_W  = $clog2(MAX_HALF + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_cpol,
  input  logic               cfg_cpha,
  input  logic               cfg_lsb_first,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic [HALF_W-1:0]  cfg_half,
  input  logic               wr_en,
  input  logic [MAX_LEN-1:0] wr_data,
  output logic               busy,
  output logic               done,
  output logic [MAX_LEN-1:0] rx_data,
  output logic               overrun,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  import spi_xfer_pkg::*;

  localparam int CNT_W = $clog2(MAX_HALF + LEAD + 1);
  localparam int IDX_W = $clog2(2 * MAX_LEN);
  localparam int BIT_W = $clog2(MAX_LEN);

  xfer_state_e state_q;

  logic [LEN_W-1:0]   len_c, len_q;
  logic [HALF_W-1:0]  half_c, half_q, half_sel;
  logic               cpha_q, lsb_q;
  logic [MAX_LEN-1:0] word_q;
  logic               accept;

  logic               fire, final_edge;
  logic [IDX_W-1:0]   edge_idx, last_idx;
  logic [LEN_W:0]     two_len;

  logic               rx_role, tx_role;
  logic [IDX_W:0]     tx_ord_full;
  logic               tx_in_range;
  logic [BIT_W-1:0]   ord_tx, ord_rx, pos_tx, pos_rx, pos_first;
  logic [MAX_LEN-1:0] asm_word;

  logic               sclk_q, mosi_q, done_q, ovr_q;
  logic [MAX_LEN-1:0] rx_q;

  spi_xfer_clamp #(.W(LEN_W), .LO(MIN_LEN), .HI(MAX_LEN)) u_len_lim (
    .raw(cfg_len), .lim(len_c)
  );

  spi_xfer_clamp #(.W(HALF_W), .LO(MIN_HALF), .HI(MAX_HALF)) u_half_lim (
    .raw(cfg_half), .lim(half_c)
  );

  assign accept   = wr_en && (state_q == XS_IDLE);
  assign half_sel = accept ? half_c : half_q;
  assign two_len  = {len_q, 1'b0};
  assign last_idx = IDX_W'(two_len - (LEN_W + 1)'(1));

  spi_xfer_timer #(
    .HALF_W(HALF_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .LEAD(LEAD)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .cpha(cfg_cpha),
    .half(half_sel), .last_idx(last_idx), .fire(fire),
    .final_edge(final_edge), .edge_idx(edge_idx)
  );

  // Even-numbered edges are leading edges. Phase 0 samples on them, phase 1 shifts on them.
  assign rx_role     = fire && (edge_idx[0] == cpha_q);
  assign tx_role     = fire && !rx_role;
  assign tx_ord_full = ({1'b0, edge_idx} + (IDX_W + 1)'(!cpha_q)) >> 1;
  assign tx_in_range = tx_ord_full < (IDX_W + 1)'(len_q);
  assign ord_tx      = BIT_W'(tx_ord_full);
  assign ord_rx      = BIT_W'(edge_idx >> 1);

  spi_xfer_bitsel #(.LEN_W(LEN_W), .BIT_W(BIT_W)) u_pos_first (
    .lsb_first(cfg_lsb_first), .len(len_c), .ord('0), .pos(pos_first)
  );

  spi_xfer_bitsel #(.LEN_W(LEN_W), .BIT_W(BIT_W)) u_pos_tx (
    .lsb_first(lsb_q), .len(len_q), .ord(ord_tx), .pos(pos_tx)
  );

  spi_xfer_bitsel #(.LEN_W(LEN_W), .BIT_W(BIT_W)) u_pos_rx (
    .lsb_first(lsb_q), .len(len_q), .ord(ord_rx), .pos(pos_rx)
  );

  spi_xfer_rxasm #(.W(MAX_LEN), .BIT_W(BIT_W)) u_rxasm (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap(rx_role),
    .pos(pos_rx), .din(miso), .word(asm_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= LEN_W'(MIN_LEN);
      half_q <= HALF_W'(MIN_HALF);
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      word_q <= '0;
    end else if (accept) begin
      len_q  <= len_c;
      half_q <= half_c;
      cpha_q <= cfg_cpha;
      lsb_q  <= cfg_lsb_first;
      word_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      case (state_q)
        XS_IDLE: if (accept) state_q <= XS_RUN;
        XS_RUN:  if (final_edge) state_q <= XS_FIN;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
      rx_q   <= '0;
    end else begin
      if (state_q == XS_IDLE) sclk_q <= cfg_cpol;
      else if (fire)          sclk_q <= ~sclk_q;

      if (accept)                          mosi_q <= wr_data[pos_first];
      else if (tx_role && tx_in_range)     mosi_q <= word_q[pos_tx];

      done_q <= (state_q == XS_FIN);
      if (state_q == XS_FIN) rx_q <= asm_word;

      if (wr_en && (state_q != XS_IDLE)) ovr_q <= 1'b1;
    end
  end

  assign busy    = (state_q != XS_IDLE);
  assign done    = done_q;
  assign rx_data = rx_q;
  assign overrun = ovr_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic cfg_cpol,
  input logic busy,
  input logic done,
  input logic overrun,
  input logic sclk,
  input logic mosi
);
  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (sclk == $past(cfg_cpol)));

  p_mosi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wr_en) |=> $stable(mosi));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy) |=> overrun);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind spi_xfer_master spi_xfer_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_cpol(cfg_cpol),
  .busy(busy), .done(done), .overrun(overrun), .sclk(sclk), .mosi(mosi)
);

// File: tb/spi_xfer_master_tb.sv
`timescale 1ns/1ps
module spi_xfer_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [4:0]  cfg_len = 5'd8;
  logic [7:0]  cfg_half = 8'd4;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        busy, done, overrun, sclk, mosi, miso;
  logic [15:0] rx_data;
  logic        lb = 1'b1;
  logic        miso_rnd = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign miso = lb ? mosi : miso_rnd;

  spi_xfer_master u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .cfg_half(cfg_half),
    .wr_en(wr_en), .wr_data(wr_data), .busy(busy), .done(done),
    .rx_data(rx_data), .overrun(overrun), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic        m_busy = 0, m_done = 0, m_sclk = 0, m_mosi = 0, m_ovr = 0;
  logic [15:0] m_rx = '0, m_acc = '0, m_word = '0;
  int          m_h, m_n, m_s, m_t;
  bit          m_cpha, m_lsb;

  function automatic int lim(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int bpos(bit lsb, int n, int j);
    return lsb ? j : (n - 1 - j);
  endfunction

  always @(negedge clk) miso_rnd <= 1'($urandom_range(0, 1));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_sclk = 0; m_mosi = 0; m_ovr = 0; m_rx = '0;
    end else begin
      logic sbit;
      sbit = lb ? m_mosi : miso_rnd;
      if (wr_en && m_busy) m_ovr = 1;
      if (!m_busy) begin
        m_done = 0;
        m_sclk = cfg_cpol;
        if (wr_en) begin
          m_h = lim(int'(cfg_half), 4, 128);
          m_n = lim(int'(cfg_len), 2, 16);
          m_cpha = cfg_cpha; m_lsb = cfg_lsb_first; m_word = wr_data;
          m_s = m_cpha ? 4 + m_h : 4;
          m_t = 0; m_acc = '0; m_busy = 1;
          m_mosi = m_word[bpos(m_lsb, m_n, 0)];
        end
      end else begin
        m_t++;
        if (m_t == m_s + (2 * m_n - 1) * m_h + 1) begin
          m_busy = 0; m_done = 1; m_rx = m_acc;
        end else if (m_t >= m_s && ((m_t - m_s) % m_h) == 0) begin
          int k;
          k = (m_t - m_s) / m_h;
          m_sclk = !m_sclk;
          if ((k % 2) == (m_cpha ? 1 : 0)) m_acc[bpos(m_lsb, m_n, k / 2)] = sbit;
          else begin
            int j;
            j = (k + (m_cpha ? 0 : 1)) / 2;
            if (j < m_n) m_mosi = m_word[bpos(m_lsb, m_n, j)];
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sclk === m_sclk, "R1", "sclk vs model", sclk, m_sclk);
      chk(mosi === m_mosi, "R6", "mosi vs model", mosi, m_mosi);
      chk(busy === m_busy, "R9", "busy vs model", busy, m_busy);
      chk(done === m_done, "R9", "done vs model", done, m_done);
      chk(rx_data === m_rx, "R6", "rx_data vs model", rx_data, m_rx);
      chk(overrun === m_ovr, "R10", "overrun vs model", overrun, m_ovr);
    end
  end

  int first_n, trans_n;

  task automatic start_word(input bit pol, input bit pha, input bit lsb,
                            input int len, input int half, input logic [15:0] d);
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    cfg_len = 5'(len); cfg_half = 8'(half); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic run_word(input bit pol, input bit pha, input bit lsb,
                          input int len, input int half, input logic [15:0] d);
    logic prev;
    int n = 0;
    start_word(pol, pha, lsb, len, half, d);
    first_n = -1; trans_n = 0; prev = sclk;
    while (!done && n < 20000) begin
      @(negedge clk); n++;
      if (sclk !== prev) begin
        if (first_n < 0) first_n = n;
        trans_n++; prev = sclk;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    chk(busy === 0 && done === 0 && overrun === 0, "R9", "reset flags", {busy, done, overrun}, 0);
    chk(sclk === 0 && mosi === 0 && rx_data === 0, "R9", "reset data", {sclk, mosi, rx_data}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Four modes, loopback: R3 R4 R5 R7 R2
    for (int m = 0; m < 4; m++) begin
      logic [15:0] d;
      bit pol, pha;
      pol = m[1]; pha = m[0];
      d = 16'h00A5 ^ 16'(m * 16'h0013);
      lb = 1'b1;
      run_word(pol, pha, 1'b0, 8, 4, d);
      if (!pha) chk(first_n == 4, "R3", "cycles to first edge", first_n, 4);
      else      chk(first_n == 8, "R4", "cycles to first edge", first_n, 8);
      chk(trans_n == 16, "R7", "edge count N=8", trans_n, 16);
      chk(rx_data == (d & 16'h00FF), "R5", "loopback word", rx_data, d & 16'h00FF);
      repeat (3) @(negedge clk);
      chk(sclk == pol, "R2", "idle level", sclk, pol);
    end

    // R2 idle follows polarity input
    cfg_cpol = 1'b1; repeat (2) @(negedge clk);
    chk(sclk == 1'b1, "R2", "idle follows cpol=1", sclk, 1);
    cfg_cpol = 1'b0; repeat (2) @(negedge clk);
    chk(sclk == 1'b0, "R2", "idle follows cpol=0", sclk, 0);

    // R6 R8 LSB first, random miso, full length
    lb = 1'b0;
    run_word(1'b0, 1'b0, 1'b1, 16, 5, 16'hC3A1);
    chk(trans_n == 32, "R7", "edge count N=16", trans_n, 32);
    repeat (10) @(negedge clk);
    chk(mosi == 1'b1, "R8", "last bit held (bit15)", mosi, 1);

    // R6 right-aligned short MSB-first word
    lb = 1'b1;
    run_word(1'b1, 1'b1, 1'b0, 5, 6, 16'hFFF3);
    chk(rx_data == 16'h0013, "R6", "5-bit msb-first rx", rx_data, 16'h0013);
    repeat (5) @(negedge clk);
    chk(mosi == 1'b1, "R8", "last bit held (bit0)", mosi, 1);
    run_word(1'b0, 1'b0, 1'b1, 6, 4, 16'h0034);
    chk(rx_data == 16'h0034, "R6", "6-bit lsb-first rx", rx_data, 16'h0034);
    repeat (5) @(negedge clk);
    chk(mosi == 1'b1, "R8", "last bit held (bit5)", mosi, 1);

    // R1 R7 clamps
    run_word(1'b0, 1'b0, 1'b0, 1, 2, 16'h0002);
    chk(first_n == 4, "R1", "half 2 cpha0 first edge", first_n, 4);
    chk(trans_n == 4, "R7", "len 1 clamps to 2", trans_n, 4);
    run_word(1'b0, 1'b1, 1'b0, 2, 2, 16'h0001);
    chk(first_n == 8, "R1", "half 2 clamps to 4 (cpha1)", first_n, 8);
    run_word(1'b1, 1'b1, 1'b0, 2, 200, 16'h0003);
    chk(first_n == 132, "R1", "half 200 clamps to 128", first_n, 132);
    chk(rx_data == 16'h0003, "R4", "slow loopback", rx_data, 3);
    run_word(1'b0, 1'b0, 1'b0, 31, 4, 16'h8001);
    chk(trans_n == 32, "R7", "len 31 clamps to 16", trans_n, 32);

    // R10 R11 write while busy with config changes
    chk(overrun == 1'b0, "R10", "overrun clear before", overrun, 0);
    start_word(1'b0, 1'b0, 1'b0, 16, 4, 16'h1234);
    repeat (20) @(negedge clk);
    cfg_lsb_first = 1'b1; cfg_cpol = 1'b1; cfg_len = 5'd3; cfg_half = 8'd9;
    cfg_cpha = 1'b1; wr_data = 16'hFFFF; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(overrun == 1'b1, "R10", "overrun set", overrun, 1);
    wait_done();
    chk(rx_data == 16'h1234, "R11", "word unaffected by mid-word changes", rx_data, 16'h1234);
    repeat (20) @(negedge clk);
    chk(overrun == 1'b1, "R10", "overrun sticky", overrun, 1);
    chk(busy == 1'b0, "R10", "ignored write started nothing", busy, 0);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule